// File: doc/BRIEF.md
# DMA Bus Ownership and Burst Governor

This block decides when a DMA engine asks for a shared system bus, how long it keeps the bus, and when it hands the bus back. A single mode register sets the policy. The start policy chooses between starting as soon as the transmit FIFO holds data and waiting until the FIFO is full. A hold bit keeps bus ownership after a transfer ends. Two burst enables and a burst-length code set the largest local-bus burst for the DMA path and for the FIFO path.

After a transfer, a held bus is given back only when one of three things happens: the arbiter asks for it, an external ownership timer expires, or software clears the hold bit. While the bus is held, new FIFO data starts the next transfer at once, without a new arbitration. DMA completion and DMA error events each set a sticky status bit, and each status bit drives its own interrupt line. Software clears a status bit by writing a one to it.

Top module: `dma_bus_gov`

## Requirements
- R1: After reset, bus_req, bus_rel, xfer_active, irq_done and irq_err are 0, and both burst limits are 1.
- R2: When mode bit 0 (start policy) is 0, an idle block raises bus_req at the first clock edge that sees fifo_empty low.
- R3: When mode bit 0 is 1, an idle block raises no bus_req while fifo_full is low, even if the FIFO holds data. It raises bus_req at the first edge that sees fifo_full high.
- R4: Once bus_req is high, the transfer begins (xfer_active high) at the edge that sees bus_gnt.
- R5: When mode bit 1 (hold) is 0, bus_rel is high for exactly one cycle, in the cycle after the edge that takes the last beat (sys_beat and xfer_last both high). bus_req is low in that cycle.
- R6: When mode bit 1 is 1, bus_req stays high and bus_rel stays low after the last beat, for as long as no release cause is present.
- R7: While the bus is held, rel_req from the arbiter produces a bus_rel pulse in the cycle after the edge that samples it.
- R8: While the bus is held, tmr_expire produces a bus_rel pulse in the cycle after the edge that samples it.
- R9: While the bus is held, a mode write that clears bit 1 produces bus_rel in the cycle after the first edge at which the register shows hold=0.
- R10: While the bus is held and no release cause is present, the start condition starts a new transfer at the next edge. bus_req stays high and no bus_rel is issued.
- R11: The DMA burst limit is 2^blen when mode bit 2 is 1, and 1 otherwise. The FIFO burst limit is 2^blen when mode bit 3 is 1, and 1 otherwise. blen is mode bits [4+BLEN_W-1:4], and a blen of 0 gives a limit of 1.
- R12: done_evt sets irq_done and err_evt sets irq_err. Each stays set until a stat_clr_wr carries a one in its own bit (bit 0 for done, bit 1 for error). A clear of the other bit has no effect on it. When an event and its clear arrive in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4+BLEN_W | Mode value: bit0 start-on-full, bit1 hold, bit2 DMA burst enable, bit3 FIFO burst enable, upper bits blen |
| fifo_empty | input | 1 | Transmit FIFO empty flag |
| fifo_full | input | 1 | Transmit FIFO full flag |
| bus_gnt | input | 1 | System bus grant |
| sys_beat | input | 1 | A system-bus beat completes this cycle |
| xfer_last | input | 1 | Qualifies sys_beat as the final beat of the transfer |
| rel_req | input | 1 | Arbiter asks for the bus back |
| tmr_expire | input | 1 | Ownership timer has expired |
| done_evt | input | 1 | DMA completion event |
| err_evt | input | 1 | DMA error event |
| stat_clr_wr | input | 1 | Status clear write strobe |
| stat_clr_data | input | 2 | Write-one-to-clear: bit0 done, bit1 error |
| bus_req | output | 1 | System bus request, held while the bus is owned |
| bus_rel | output | 1 | One-cycle bus release pulse |
| xfer_active | output | 1 | A transfer is in progress on the system bus |
| dma_burst_max | output | 1<<BLEN_W | Largest DMA local-bus burst, in beats |
| fifo_burst_max | output | 1<<BLEN_W | Largest FIFO local-bus burst, in beats |
| irq_done | output | 1 | Completion interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The bench builds the block with the default BLEN_W of 3. At that size the whole burst-limit space can be swept: all eight blen codes against all four combinations of the two enables, compared on both paths with a power of two computed in the bench. The same small mode word also lets the bench drive every ownership path in turn. These are the immediate and full start policies, the plain release, and each of the three causes that end a hold, plus a restart from hold. Each check is timed to the edge at which the state register changes.

// File: rtl/dma_bus_gov.sv
module dma_bus_gov #(
  parameter int BLEN_W = 3,
  localparam int MODE_W = 4 + BLEN_W,
  localparam int BURST_W = 1 << BLEN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic [MODE_W-1:0]  mode_wdata,
  input  logic               fifo_empty,
  input  logic               fifo_full,
  input  logic               bus_gnt,
  input  logic               sys_beat,
  input  logic               xfer_last,
  input  logic               rel_req,
  input  logic               tmr_expire,
  input  logic               done_evt,
  input  logic               err_evt,
  input  logic               stat_clr_wr,
  input  logic [1:0]         stat_clr_data,
  output logic               bus_req,
  output logic               bus_rel,
  output logic               xfer_active,
  output logic [BURST_W-1:0] dma_burst_max,
  output logic [BURST_W-1:0] fifo_burst_max,
  output logic               irq_done,
  output logic               irq_err
);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_OWN, S_HOLD, S_REL} own_t;

  own_t              st, st_nxt;
  logic [MODE_W-1:0] mode_q;
  logic              done_q, err_q;

  wire               start_on_full = mode_q[0];
  wire               hold          = mode_q[1];
  wire               dma_ben       = mode_q[2];
  wire               fifo_ben      = mode_q[3];
  wire [BLEN_W-1:0]  blen          = mode_q[MODE_W-1:4];

  wire start_ok  = start_on_full ? fifo_full : !fifo_empty;
  wire last_beat = sys_beat && xfer_last;
  wire give_back = rel_req || tmr_expire || !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_wr) mode_q <= mode_wdata;
  end

  always_comb begin
    st_nxt = st;
    unique case (st)
      S_IDLE: if (start_ok) st_nxt = S_REQ;
      S_REQ:  if (bus_gnt) st_nxt = S_OWN;
      S_OWN:  if (last_beat) st_nxt = hold ? S_HOLD : S_REL;
      S_HOLD: if (give_back) st_nxt = S_REL;
              else if (start_ok) st_nxt = S_OWN;
      S_REL:  st_nxt = S_IDLE;
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else st <= st_nxt;
  end

  assign bus_req     = (st == S_REQ) || (st == S_OWN) || (st == S_HOLD);
  assign bus_rel     = (st == S_REL);
  assign xfer_active = (st == S_OWN);

  assign dma_burst_max  = dma_ben  ? (BURST_W'(1) << blen) : BURST_W'(1);
  assign fifo_burst_max = fifo_ben ? (BURST_W'(1) << blen) : BURST_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (done_evt) done_q <= 1'b1;
      else if (stat_clr_wr && stat_clr_data[0]) done_q <= 1'b0;
      if (err_evt) err_q <= 1'b1;
      else if (stat_clr_wr && stat_clr_data[1]) err_q <= 1'b0;
    end
  end

  assign irq_done = done_q;
  assign irq_err  = err_q;

  assert_wait_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start_on_full && !fifo_full) |=> !bus_req);

  assert_rel_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rel |=> !bus_rel);

  assert_last_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OWN && last_beat && !hold) |=> (bus_rel && !bus_req));

  assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && hold && !rel_req && !tmr_expire) |=> (bus_req && !bus_rel));

  assert_arb_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && rel_req) |=> bus_rel);

  assert_timer_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && tmr_expire) |=> bus_rel);

  assert_burst_pow2_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dma_burst_max) == 1 && $countones(fifo_burst_max) == 1));

  assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done && !(stat_clr_wr && stat_clr_data[0])) |=> irq_done);

endmodule

// File: tb/dma_bus_gov_tb.sv
module dma_bus_gov_tb;
  localparam int BLEN_W = 3;
  localparam int MODE_W = 4 + BLEN_W;
  localparam int BURST_W = 1 << BLEN_W;

  logic clk = 0, rst_n = 0;
  logic mode_wr = 0;
  logic [MODE_W-1:0] mode_wdata = '0;
  logic fifo_empty = 1, fifo_full = 0, bus_gnt = 0, sys_beat = 0, xfer_last = 0;
  logic rel_req = 0, tmr_expire = 0, done_evt = 0, err_evt = 0, stat_clr_wr = 0;
  logic [1:0] stat_clr_data = '0;
  logic bus_req, bus_rel, xfer_active, irq_done, irq_err;
  logic [BURST_W-1:0] dma_burst_max, fifo_burst_max;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_bus_gov #(.BLEN_W(BLEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .bus_gnt(bus_gnt),
    .sys_beat(sys_beat), .xfer_last(xfer_last), .rel_req(rel_req),
    .tmr_expire(tmr_expire), .done_evt(done_evt), .err_evt(err_evt),
    .stat_clr_wr(stat_clr_wr), .stat_clr_data(stat_clr_data),
    .bus_req(bus_req), .bus_rel(bus_rel), .xfer_active(xfer_active),
    .dma_burst_max(dma_burst_max), .fifo_burst_max(fifo_burst_max),
    .irq_done(irq_done), .irq_err(irq_err));

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    @(negedge clk);
    mode_wr = 0; bus_gnt = 0; sys_beat = 0; xfer_last = 0; rel_req = 0;
    tmr_expire = 0; done_evt = 0; err_evt = 0; stat_clr_wr = 0; stat_clr_data = '0;
  endtask

  task automatic wr_mode(logic [MODE_W-1:0] v);
    @(negedge clk); mode_wr = 1; mode_wdata = v;
    edge1();
    @(negedge clk); mode_wr = 0;
  endtask

  // Starts a transfer in immediate mode and ends at the edge taking the last beat (+1ns)
  task automatic run_xfer();
    @(negedge clk); fifo_empty = 0;
    edge1();
    @(negedge clk); bus_gnt = 1;
    edge1();
    @(negedge clk); sys_beat = 1; xfer_last = 1; fifo_empty = 1; bus_gnt = 0;
    edge1();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 bus_req", bus_req, 0);
    chk("R1 bus_rel", bus_rel, 0);
    chk("R1 xfer_active", xfer_active, 0);
    chk("R1 irq_done", irq_done, 0);
    chk("R1 irq_err", irq_err, 0);
    chk("R1 dma_burst_max", dma_burst_max, 1);
    chk("R1 fifo_burst_max", fifo_burst_max, 1);

    // R11: exhaustive sweep of blen and both enables
    for (int b = 0; b < (1 << BLEN_W); b++) begin
      for (int e = 0; e < 4; e++) begin
        wr_mode(MODE_W'((b << 4) | (e << 2)));
        chk("R11 dma limit", dma_burst_max, (e & 1) ? (1 << b) : 1);
        chk("R11 fifo limit", fifo_burst_max, (e & 2) ? (1 << b) : 1);
      end
    end

    // R2, R4, R5: immediate start, plain release
    wr_mode(MODE_W'(0));
    chk("R2 idle no req", bus_req, 0);
    @(negedge clk); fifo_empty = 0;
    edge1();
    chk("R2 req on data", bus_req, 1);
    chk("R4 not yet active", xfer_active, 0);
    @(negedge clk); bus_gnt = 1;
    edge1();
    chk("R4 active on grant", xfer_active, 1);
    @(negedge clk); bus_gnt = 0; sys_beat = 1; xfer_last = 0;
    edge1();
    chk("R5 mid beat keeps req", bus_req, 1);
    @(negedge clk); xfer_last = 1; fifo_empty = 1;
    edge1();
    chk("R5 rel after last", bus_rel, 1);
    chk("R5 req low on rel", bus_req, 0);
    quiet();
    #1; edge1();
    chk("R5 rel one cycle", bus_rel, 0);

    // R3: wait-full policy
    wr_mode(MODE_W'(1));
    @(negedge clk); fifo_empty = 0; fifo_full = 0;
    edge1(); edge1(); edge1();
    chk("R3 partial no req", bus_req, 0);
    @(negedge clk); fifo_full = 1;
    edge1();
    chk("R3 req on full", bus_req, 1);
    @(negedge clk); bus_gnt = 1;
    edge1();
    @(negedge clk); bus_gnt = 0; sys_beat = 1; xfer_last = 1; fifo_full = 0; fifo_empty = 1;
    edge1();
    chk("R3 release", bus_rel, 1);
    quiet();

    // R6, R7: hold, arbiter release
    wr_mode(MODE_W'(2));
    run_xfer();
    chk("R6 held req", bus_req, 1);
    chk("R6 no rel", bus_rel, 0);
    quiet();
    edge1(); edge1();
    chk("R6 still held", bus_req, 1);
    chk("R6 still no rel", bus_rel, 0);
    @(negedge clk); rel_req = 1;
    edge1();
    chk("R7 arbiter release", bus_rel, 1);
    quiet();

    // R8: timer release
    run_xfer();
    quiet();
    edge1();
    chk("R8 held before timer", bus_req, 1);
    @(negedge clk); tmr_expire = 1;
    edge1();
    chk("R8 timer release", bus_rel, 1);
    quiet();

    // R10: restart from hold
    run_xfer();
    quiet();
    @(negedge clk); fifo_empty = 0;
    edge1();
    chk("R10 restart active", xfer_active, 1);
    chk("R10 req kept", bus_req, 1);
    chk("R10 no rel", bus_rel, 0);
    @(negedge clk); sys_beat = 1; xfer_last = 1; fifo_empty = 1;
    edge1();
    chk("R10 back to hold", bus_req, 1);
    quiet();

    // R9: clearing hold bit releases
    @(negedge clk); mode_wr = 1; mode_wdata = MODE_W'(0);
    edge1();
    chk("R9 not yet released", bus_rel, 0);
    @(negedge clk); mode_wr = 0;
    edge1();
    chk("R9 release on clear", bus_rel, 1);
    quiet();

    // R12: sticky interrupts
    @(negedge clk); done_evt = 1;
    edge1();
    chk("R12 done set", irq_done, 1);
    chk("R12 err untouched", irq_err, 0);
    quiet();
    @(negedge clk); stat_clr_wr = 1; stat_clr_data = 2'b10;
    edge1();
    chk("R12 wrong clear ignored", irq_done, 1);
    quiet();
    @(negedge clk); err_evt = 1; stat_clr_wr = 1; stat_clr_data = 2'b10;
    edge1();
    chk("R12 err set wins", irq_err, 1);
    quiet();
    @(negedge clk); stat_clr_wr = 1; stat_clr_data = 2'b01;
    edge1();
    chk("R12 done cleared", irq_done, 0);
    chk("R12 err kept", irq_err, 1);
    quiet();
    @(negedge clk); stat_clr_wr = 1; stat_clr_data = 2'b10;
    edge1();
    chk("R12 err cleared", irq_err, 0);
    quiet();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule